// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Control Register Block

This block receives configuration words over a three-wire serial port (serial clock, serial data, load strobe) and stores them in four 22-bit registers chosen by a 2-bit address sent at the end of each word. From the stored settings it picks which of two 3-bit charge-pump current codes is active, and it drives the charge-pump tri-state, polarity and counter-reset controls. The remaining function fields are brought out unchanged.

A fast-lock mode gives a synthesizer loop a higher current for a set settling interval. The mode is armed when the function register's fast-lock enable field is 11 and the gain bit of the divider register is then written as 1. The fast code drives the output until a set number of phase-detector pulses has been counted. The block then returns to the normal code and clears the gain bit by itself. An initialization write holds the charge pump in tri-state and the counters in reset until the next divider write.

All serial inputs are sampled in the `clk` domain and must be slower than `clk`. The serial port applies no back-pressure: every rising edge of the load strobe commits one word. The register-field outputs are plain level signals with no handshake.

Top module: `fastlock_ctrl`

## Requirements
- R1: While `ser_le` is low, each rising `ser_clk` edge shifts `ser_dat` into a 24-bit shift register. The word is sent as data bit 21 first down to data bit 0, then address bit 1 and address bit 0. A rising `ser_le` commits the last 24 bits shifted in, however many bits were sent.
- R2: A committed word writes its 22 data bits into the register at its address. Address 0 is the reference register, 1 the divider register, 2 the function register and 3 the initialization register. `rd_data` always shows the register selected by `rd_sel`.
- R3: After reset all four registers read 0, `cp_code` is 0, `cp_hiz`, `ctr_rst` and `fast_on` are 0.
- R4: The gain bit is bit 19 of the divider register. The active function word is whichever of registers 2 and 3 was written last. The normal code is in bits 15:13 and the fast code in bits 18:16. `cp_code` is the fast code while the gain bit is 1 and the normal code while it is 0.
- R5: The fast-lock enable field is in bits 8:7 and the timer field T in bits 12:9. If the enable field is 11 when the divider register is written with gain 1, `fast_on` rises. The fast code drives the output for 3+4*T rising edges of `pfd_tick`. After that, `fast_on` falls, the gain bit reads back 0 and the normal code is output.
- R6: Writing gain 1 to the divider register again during a fast-lock interval restarts the count from its full length.
- R7: A write to address 3 ends any fast-lock interval. It also forces `cp_hiz` and `ctr_rst` to 1 until the next write to address 1, which releases both.
- R8: Bit 6 of the active function word forces `cp_hiz` to 1.
- R9: The active function word drives these outputs: `cp_pol` from bit 5, `ctr_rst` from bit 0 (ORed with the R7 hold), `pre_sel` from bits 21:20, `pd_sync` from bit 19, `ld_sel` from bits 4:2 and `pd_async` from bit 1.
- R10: `ser_clk` edges while `ser_le` is high shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled in `clk` |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Load strobe; rising edge commits a word |
| pfd_tick | input | 1 | Phase-detector rate pulse; rising edges are counted |
| rd_sel | input | 2 | Read-back register select |
| rd_data | output | 22 | Contents of the selected register |
| cp_code | output | 3 | Selected charge-pump current code |
| cp_hiz | output | 1 | Charge pump in high impedance |
| cp_pol | output | 1 | Charge-pump polarity |
| ctr_rst | output | 1 | Divider counter reset |
| fast_on | output | 1 | Fast-lock interval in progress |
| pre_sel | output | 2 | Prescaler select field |
| ld_sel | output | 3 | Lock-detect select field |
| pd_sync | output | 1 | Synchronous power-down select field |
| pd_async | output | 1 | Power-down request field |

## Verification
A committed word reaches the registers and every output at most three `clk` edges after `ser_le` rises: one edge samples the pins, one registers the strobe and one updates the register. The bench holds the strobe and then waits seven edges before it samples. A counted `pfd_tick` edge that ends a fast-lock interval shows on `fast_on` one edge later and on the gain bit and `cp_code` two edges later. The bench therefore samples four edges after that pulse, and it checks the interval one pulse short of its end as well as at its end. Read-back is combinational, so it is sampled a short delay after `rd_sel` changes at a falling clock edge.

// File: rtl/fl_pkg.sv
package fl_pkg;
  parameter int DATA_W = 22;
  parameter int ADDR_W = 2;
  parameter int WORD_W = DATA_W + ADDR_W;
  parameter int NREG   = 1 << ADDR_W;
  parameter int CODE_W = 3;
  parameter int TMR_W  = 4;
  parameter int CNT_W  = TMR_W + 2;
  parameter int GAIN_BIT = 19;

  localparam int A_REF  = 0;
  localparam int A_DIV  = 1;
  localparam int A_FUNC = 2;
  localparam int A_INIT = 3;

  typedef struct packed {
    logic [1:0]        psel;
    logic              pd_sync;
    logic [CODE_W-1:0] code_fast;
    logic [CODE_W-1:0] code_norm;
    logic [TMR_W-1:0]  tmr;
    logic [1:0]        fl_en;
    logic              cp_off;
    logic              cp_pos;
    logic [2:0]        ld_sel;
    logic              pd_async;
    logic              ctr_clr;
  } func_t;
endpackage

// File: rtl/fl_shift_in.sv
module fl_shift_in
  import fl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              sle,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  logic sclk_d, sclk_p, sdat_d, sle_d, sle_p;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      sclk_p   <= 1'b0;
      sdat_d   <= 1'b0;
      sle_d    <= 1'b0;
      sle_p    <= 1'b0;
      sh       <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk;
      sclk_p   <= sclk_d;
      sdat_d   <= sdat;
      sle_d    <= sle;
      sle_p    <= sle_d;
      if (sclk_d && !sclk_p && !sle_d)
        sh <= {sh[WORD_W-2:0], sdat_d};
      word_vld <= sle_d && !sle_p;
    end
  end

  assign word = sh;

  // R10: no shifting while the load strobe is high
  a_r10_no_shift_le_high: assert property (@(posedge clk) disable iff (!rst_n)
    sle_d |=> (sh == $past(sh)));

  // R1: one commit per strobe edge
  a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
endmodule

// File: rtl/fl_fast_timer.sv
module fl_fast_timer
  import fl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic             tick,
  input  logic [TMR_W-1:0] tmr,
  output logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;
  logic             tick_p;
  logic             tick_rise;

  assign load      = CNT_W'(3) + {tmr, 2'b00};
  assign tick_rise = tick && !tick_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      expire <= 1'b0;
      tick_p <= 1'b0;
    end else begin
      tick_p <= tick;
      expire <= 1'b0;
      if (cancel) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (start) begin
        cnt    <= load;
        active <= 1'b1;
      end else if (active && tick_rise) begin
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          expire <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  // R5: a running interval always has pulses left to count
  a_r5_live_count: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != '0));

  // R6: an arming write always (re)starts the interval
  a_r6_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cancel) |=> active);

  // R5: expiry only ends a running interval
  a_r5_expire_ends: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (!active && $past(active)));
endmodule

// File: rtl/fl_regs.sv
module fl_regs
  import fl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              expire,
  input  logic [ADDR_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output func_t             fn,
  output logic              gain,
  output logic              hold,
  output logic              start,
  output logic              cancel
);
  logic [DATA_W-1:0] regs [NREG];
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;
  logic [NREG-1:0]   we;
  logic              last_init;

  assign wa = word[ADDR_W-1:0];
  assign wd = word[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = wr_vld && (wa == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      last_init <= 1'b0;
      hold      <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we[i])
          regs[i] <= wd;
        else if (i == A_DIV && expire)
          regs[i][GAIN_BIT] <= 1'b0;
      end
      if (we[A_FUNC]) last_init <= 1'b0;
      if (we[A_INIT]) last_init <= 1'b1;
      if (we[A_INIT]) hold <= 1'b1;
      else if (we[A_DIV]) hold <= 1'b0;
    end
  end

  assign fn      = func_t'(last_init ? regs[A_INIT] : regs[A_FUNC]);
  assign gain    = regs[A_DIV][GAIN_BIT];
  assign start   = we[A_DIV] && wd[GAIN_BIT] && (fn.fl_en == 2'b11);
  assign cancel  = we[A_INIT];
  assign rd_data = regs[rd_sel];

  // R7: an initialization write holds the pump off
  a_r7_init_holds: assert property (@(posedge clk) disable iff (!rst_n)
    we[A_INIT] |=> hold);

  // R5: expiry clears the gain bit unless a divider write lands with it
  a_r5_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !we[A_DIV]) |=> !gain);

  // R2: the reference register changes only when it is written
  a_r2_ref_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we[A_REF] |=> $stable(regs[A_REF]));
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
  import fl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  input  logic              pfd_tick,
  input  logic [ADDR_W-1:0] rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [CODE_W-1:0] cp_code,
  output logic              cp_hiz,
  output logic              cp_pol,
  output logic              ctr_rst,
  output logic              fast_on,
  output logic [1:0]        pre_sel,
  output logic [2:0]        ld_sel,
  output logic              pd_sync,
  output logic              pd_async
);
  logic [WORD_W-1:0] word;
  logic              word_vld;
  func_t             fn;
  logic              gain, hold, start, cancel, expire;

  fl_shift_in u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(ser_clk), .sdat(ser_dat), .sle(ser_le),
    .word(word), .word_vld(word_vld)
  );

  fl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_vld(word_vld), .word(word), .expire(expire),
    .rd_sel(rd_sel), .rd_data(rd_data), .fn(fn), .gain(gain), .hold(hold),
    .start(start), .cancel(cancel)
  );

  fl_fast_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel), .tick(pfd_tick),
    .tmr(fn.tmr), .active(fast_on), .expire(expire)
  );

  assign cp_code  = gain ? fn.code_fast : fn.code_norm;
  assign cp_hiz   = fn.cp_off | hold;
  assign ctr_rst  = fn.ctr_clr | hold;
  assign cp_pol   = fn.cp_pos;
  assign pre_sel  = fn.psel;
  assign ld_sel   = fn.ld_sel;
  assign pd_sync  = fn.pd_sync;
  assign pd_async = fn.pd_async;
endmodule

// File: tb/test_fastlock_ctrl.sv
`timescale 1ns/1ps
module test_fastlock_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, pfd_tick = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [21:0] rd_data;
  logic [2:0]  cp_code, ld_sel;
  logic [1:0]  pre_sel;
  logic cp_hiz, cp_pol, ctr_rst, fast_on, pd_sync, pd_async;

  int n_chk = 0, n_fail = 0;

  logic [21:0] m_reg [4];
  logic        m_last_init = 1'b0, m_hold = 1'b0;
  logic [23:0] m_sh = '0;

  always #10 clk = ~clk;

  fastlock_ctrl i_fastlock_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .pfd_tick(pfd_tick), .rd_sel(rd_sel), .rd_data(rd_data), .cp_code(cp_code),
    .cp_hiz(cp_hiz), .cp_pol(cp_pol), .ctr_rst(ctr_rst), .fast_on(fast_on),
    .pre_sel(pre_sel), .ld_sel(ld_sel), .pd_sync(pd_sync), .pd_async(pd_async)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] mk_fn(input logic [2:0] cf, input logic [2:0] cn, input logic [3:0] t,
                                        input logic [1:0] fl, input logic off, input logic pos, input logic clr);
    return {2'b01, 1'b0, cf, cn, t, fl, off, pos, 3'b001, 1'b0, clr};
  endfunction

  function automatic logic [21:0] act_fn();
    return m_last_init ? m_reg[3] : m_reg[2];
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [21:0] d);
    m_reg[a] = d;
    if (a == 2'd2) m_last_init = 1'b0;
    if (a == 2'd3) begin m_last_init = 1'b1; m_hold = 1'b1; end
    if (a == 2'd1) m_hold = 1'b0;
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic latch();
    ser_le = 1'b1;
    repeat (3) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
    model_write(m_sh[1:0], m_sh[23:2]);
  endtask

  task automatic send_bits(input int n, input logic [63:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      ser_bit(v[i]);
      m_sh = {m_sh[22:0], v[i]};
    end
    latch();
  endtask

  task automatic write_word(input logic [1:0] a, input logic [21:0] d);
    send_bits(24, {40'd0, d, a});
  endtask

  task automatic tick();
    @(negedge clk) pfd_tick = 1'b1;
    @(negedge clk) pfd_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [21:0] f;
    logic [2:0]  ec;
    f  = act_fn();
    ec = m_reg[1][19] ? f[18:16] : f[15:13];
    for (int s = 0; s < 4; s++) begin
      @(negedge clk) rd_sel = 2'(s);
      #1 chk({req, " R2 readback"}, $sformatf("reg%0d", s), 32'(rd_data), 32'(m_reg[s]));
    end
    chk({req, " R4"}, "cp_code", 32'(cp_code), 32'(ec));
    chk({req, " R8"}, "cp_hiz", 32'(cp_hiz), 32'(f[6] | m_hold));
    chk({req, " R9"}, "cp_pol", 32'(cp_pol), 32'(f[5]));
    chk({req, " R9"}, "ctr_rst", 32'(ctr_rst), 32'(f[0] | m_hold));
    chk({req, " R9"}, "fields", {22'd0, pre_sel, ld_sel, pd_sync, pd_async, 3'd0},
        {22'd0, f[21:20], f[4:2], f[19], f[1], 3'd0});
  endtask

  task automatic run_fast(input logic [3:0] t);
    int k;
    k = 3 + 4 * int'(t);
    write_word(2'd2, mk_fn(3'd6, 3'd2, t, 2'b11, 1'b0, 1'b1, 1'b0));
    write_word(2'd1, {2'b00, 1'b1, 13'd40, 6'd9});
    chk("R5", "fast_on at arm", 32'(fast_on), 32'd1);
    chk("R5", "fast code at arm", 32'(cp_code), 32'd6);
    for (int i = 0; i < k - 1; i++) tick();
    repeat (4) @(negedge clk);
    chk("R5", "fast_on one pulse short", 32'(fast_on), 32'd1);
    chk("R5", "code one pulse short", 32'(cp_code), 32'd6);
    tick();
    repeat (4) @(negedge clk);
    chk("R5", "fast_on after count", 32'(fast_on), 32'd0);
    m_reg[1][19] = 1'b0;
    check_all("R5 expiry");
  endtask

  initial begin
    int unsigned seed;
    logic [21:0] d;
    logic [1:0]  a;
    seed = $urandom(32'd7321);
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3", "fast_on after reset", 32'(fast_on), 32'd0);
    check_all("R3 reset");

    for (int i = 0; i < 24; i++) begin
      a = 2'($urandom_range(3, 0));
      d = 22'($urandom());
      write_word(a, d);
      check_all("R2 random");
    end

    // R10: edges with the strobe high are ignored, then a bare re-commit
    write_word(2'd0, 22'h2A5A5);
    ser_le = 1'b1;
    for (int i = 0; i < 8; i++) ser_bit(1'b1);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
    latch();
    check_all("R10 ignored shifts");

    // R1: extra leading bits, then a short burst
    send_bits(30, {34'd0, 6'b101101, 22'h13579, 2'd0});
    check_all("R1 long frame");
    send_bits(20, {44'd0, 20'hB3C5E});
    check_all("R1 short frame");

    // R4: static selection with the fast-lock enable not 11
    write_word(2'd2, mk_fn(3'd5, 3'd1, 4'd3, 2'b01, 1'b0, 1'b0, 1'b1));
    write_word(2'd1, {2'b00, 1'b1, 13'd100, 6'd3});
    check_all("R4 gain one");
    chk("R4", "no timer when not armed", 32'(fast_on), 32'd0);
    write_word(2'd1, {2'b00, 1'b0, 13'd100, 6'd3});
    check_all("R4 gain zero");

    // R8: tri-state bit
    write_word(2'd2, mk_fn(3'd5, 3'd1, 4'd0, 2'b00, 1'b1, 1'b1, 1'b0));
    check_all("R8 tri-state");

    // R5: shortest, mid and longest intervals
    run_fast(4'd0);
    run_fast(4'd2);
    run_fast(4'd15);

    // R6: restart during an interval (T=1 gives 7 pulses)
    write_word(2'd2, mk_fn(3'd7, 3'd3, 4'd1, 2'b11, 1'b0, 1'b0, 1'b0));
    write_word(2'd1, {2'b00, 1'b1, 13'd50, 6'd1});
    for (int i = 0; i < 5; i++) tick();
    write_word(2'd1, {2'b00, 1'b1, 13'd50, 6'd1});
    for (int i = 0; i < 6; i++) tick();
    repeat (4) @(negedge clk);
    chk("R6", "still fast after restart", 32'(fast_on), 32'd1);
    chk("R6", "fast code after restart", 32'(cp_code), 32'd7);
    tick();
    repeat (4) @(negedge clk);
    chk("R6", "expired after full length", 32'(fast_on), 32'd0);
    m_reg[1][19] = 1'b0;
    check_all("R6 end");

    // R7: initialization write cancels and holds, divider write releases
    write_word(2'd1, {2'b00, 1'b1, 13'd50, 6'd1});
    tick();
    write_word(2'd3, mk_fn(3'd4, 3'd6, 4'd5, 2'b11, 1'b0, 1'b1, 1'b0));
    chk("R7", "timer cancelled", 32'(fast_on), 32'd0);
    check_all("R7 hold");
    write_word(2'd1, {2'b00, 1'b0, 13'd77, 6'd5});
    chk("R7", "no timer on release", 32'(fast_on), 32'd0);
    check_all("R7 release");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule